// File: doc/BRIEF.md
# Shadow Color Remapper

This block sits between a last-level cache and the off-chip memory port and changes where a page lands in the cache without moving the page in DRAM. The page color is the group of address bits that belong both to the cache set index and to the physical page number. It therefore picks the set, and in a 16-bank cache laid out as a 4x4 grid it picks the bank.

On the cache-bound path the block takes a physical address and a replacement color. It writes the replacement color into the color field. The color that was there is moved into spare upper address bits, called the shadow field, which regular physical addresses never use. On the memory-bound path, for misses and writebacks, it undoes the change: the shadow field goes back into the color field and the shadow field is cleared. No lookup table is needed, because the displaced color travels inside the address itself.

Both paths are purely combinational. Each carries a valid/ready pair through the block unchanged. With the default parameters the address is 48 bits, the page offset is bits [11:0], the color field is bits [15:12], and the shadow field is bits [47:44].

Top module: `shadow_color_remap`

## Requirements
- R1: On the cache-bound path, bits [15:12] of `llc_addr` equal `fill_color`.
- R2: On the cache-bound path, bits [47:44] of `llc_addr` equal bits [15:12] of `fill_addr` (the displaced color).
- R3: On the cache-bound path, bits [11:0] and [43:16] of `llc_addr` equal the same bits of `fill_addr`.
- R4: On the memory-bound path, bits [15:12] of `mem_addr` equal bits [47:44] of `evict_addr`, and bits [47:44] of `mem_addr` are zero.
- R5: On the memory-bound path, bits [11:0] and [43:16] of `mem_addr` equal the same bits of `evict_addr`.
- R6: Passing an address through the cache-bound path and then the memory-bound path gives back that address with bits [47:44] cleared. For an address whose bits [47:44] are zero, this is the exact original address.
- R7: When `fill_color` equals bits [15:12] of `fill_addr`, `llc_addr` equals `fill_addr` in every bit except [47:44], which hold that color.
- R8: In the same cycle, `llc_valid` equals `fill_valid` and `fill_ready` equals `llc_ready`. With `fill_valid` low, `llc_valid` is low.
- R9: In the same cycle, `mem_valid` equals `evict_valid` and `evict_ready` equals `mem_ready`. With `evict_valid` low, `mem_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fill_valid | input | 1 | Cache-bound request present |
| fill_ready | output | 1 | Cache-bound request accepted |
| fill_addr | input | 48 | Regular physical address from the cache side |
| fill_color | input | 4 | Replacement color for this page |
| llc_valid | output | 1 | Remapped request present toward the cache |
| llc_ready | input | 1 | Cache accepts the remapped request |
| llc_addr | output | 48 | Remapped address used for cache lookup |
| evict_valid | input | 1 | Memory-bound request (miss or writeback) present |
| evict_ready | output | 1 | Memory-bound request accepted |
| evict_addr | input | 48 | Remapped address leaving the cache |
| mem_valid | output | 1 | Rebuilt request present toward memory |
| mem_ready | input | 1 | Memory port accepts the rebuilt request |
| mem_addr | output | 48 | Regular physical address for off-chip access |

## Verification
The bench drives colors 0 and 15, all-zero and all-one addresses, and a replacement color equal to the existing one. It aims at splice boundaries that are off by one bit: a wrong boundary would show as a corrupted bit 11, 16, 43 or 44 next to an otherwise correct field. It also closes the loop by feeding `llc_addr` straight into `evict_addr`. A design that clears the wrong field, or restores the replacement color instead of the saved one, would then return a different page than was requested. Ready and valid are randomized independently on both paths, so a swapped or crossed handshake wire shows as a mismatch in the first few cycles.

// File: rtl/scr_pkg.sv
package scr_pkg;

    // Default geometry: 48-bit physical address, 4 KiB pages, 16 colors.
    localparam int unsigned DEF_ADDR_W  = 48;
    localparam int unsigned DEF_OFS_W   = 12;
    localparam int unsigned DEF_COLOR_W = 4;

    // Low bit of the shadow field: the top COLOR_W bits of the address.
    function automatic int unsigned shadow_lo(input int unsigned addr_w,
                                              input int unsigned color_w);
        return addr_w - color_w;
    endfunction

endpackage

// File: rtl/scr_splice.sv
// Replaces one FW-bit field starting at bit LO of a W-bit word.
module scr_splice #(
    parameter int unsigned W  = 48,
    parameter int unsigned LO = 12,
    parameter int unsigned FW = 4
) (
    input  logic [W-1:0]  base,
    input  logic [FW-1:0] field,
    output logic [W-1:0]  spliced
);
    localparam logic [W-1:0] FMASK = {{(W-FW){1'b0}}, {FW{1'b1}}} << LO;

    logic [W-1:0] placed;

    always_comb begin
        placed  = {{(W-FW){1'b0}}, field} << LO;
        spliced = (base & ~FMASK) | (placed & FMASK);
    end
endmodule

// File: rtl/scr_fwd.sv
// Cache-bound rewrite: new color in, old color parked in the shadow field.
module scr_fwd #(
    parameter int unsigned ADDR_W  = 48,
    parameter int unsigned OFS_W   = 12,
    parameter int unsigned COLOR_W = 4
) (
    input  logic [ADDR_W-1:0]  phys_addr,
    input  logic [COLOR_W-1:0] new_color,
    output logic [ADDR_W-1:0]  remap_addr
);
    localparam int unsigned SHADOW_LO = scr_pkg::shadow_lo(ADDR_W, COLOR_W);

    logic [COLOR_W-1:0] old_color;
    logic [ADDR_W-1:0]  recolored;

    assign old_color = phys_addr[OFS_W +: COLOR_W];

    scr_splice #(.W(ADDR_W), .LO(OFS_W), .FW(COLOR_W)) u_color (
        .base    (phys_addr),
        .field   (new_color),
        .spliced (recolored)
    );

    scr_splice #(.W(ADDR_W), .LO(SHADOW_LO), .FW(COLOR_W)) u_shadow (
        .base    (recolored),
        .field   (old_color),
        .spliced (remap_addr)
    );
endmodule

// File: rtl/scr_rev.sv
// Memory-bound rewrite: saved color restored, shadow field zeroed.
module scr_rev #(
    parameter int unsigned ADDR_W  = 48,
    parameter int unsigned OFS_W   = 12,
    parameter int unsigned COLOR_W = 4
) (
    input  logic [ADDR_W-1:0] remap_addr,
    output logic [ADDR_W-1:0] phys_addr
);
    localparam int unsigned SHADOW_LO = scr_pkg::shadow_lo(ADDR_W, COLOR_W);

    logic [COLOR_W-1:0] saved_color;
    logic [ADDR_W-1:0]  restored;

    assign saved_color = remap_addr[SHADOW_LO +: COLOR_W];

    scr_splice #(.W(ADDR_W), .LO(OFS_W), .FW(COLOR_W)) u_color (
        .base    (remap_addr),
        .field   (saved_color),
        .spliced (restored)
    );

    scr_splice #(.W(ADDR_W), .LO(SHADOW_LO), .FW(COLOR_W)) u_clear (
        .base    (restored),
        .field   ({COLOR_W{1'b0}}),
        .spliced (phys_addr)
    );
endmodule

// File: rtl/shadow_color_remap.sv
module shadow_color_remap #(
    parameter int unsigned ADDR_W  = scr_pkg::DEF_ADDR_W,
    parameter int unsigned OFS_W   = scr_pkg::DEF_OFS_W,
    parameter int unsigned COLOR_W = scr_pkg::DEF_COLOR_W
) (
    input  logic               fill_valid,
    output logic               fill_ready,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic [COLOR_W-1:0] fill_color,
    output logic               llc_valid,
    input  logic               llc_ready,
    output logic [ADDR_W-1:0]  llc_addr,
    input  logic               evict_valid,
    output logic               evict_ready,
    input  logic [ADDR_W-1:0]  evict_addr,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [ADDR_W-1:0]  mem_addr
);
    // Handshakes pass straight through; the address rewrite adds no state.
    assign llc_valid   = fill_valid;
    assign fill_ready  = llc_ready;
    assign mem_valid   = evict_valid;
    assign evict_ready = mem_ready;

    scr_fwd #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .COLOR_W(COLOR_W)) u_fwd (
        .phys_addr  (fill_addr),
        .new_color  (fill_color),
        .remap_addr (llc_addr)
    );

    scr_rev #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .COLOR_W(COLOR_W)) u_rev (
        .remap_addr (evict_addr),
        .phys_addr  (mem_addr)
    );
endmodule

// File: rtl/scr_check.sv
module scr_check #(
    parameter int unsigned ADDR_W  = 48,
    parameter int unsigned OFS_W   = 12,
    parameter int unsigned COLOR_W = 4
) (
    input logic               fill_valid,
    input logic               fill_ready,
    input logic [ADDR_W-1:0]  fill_addr,
    input logic [COLOR_W-1:0] fill_color,
    input logic               llc_valid,
    input logic               llc_ready,
    input logic [ADDR_W-1:0]  llc_addr,
    input logic               evict_valid,
    input logic               evict_ready,
    input logic [ADDR_W-1:0]  evict_addr,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic [ADDR_W-1:0]  mem_addr
);
    localparam int unsigned  SHADOW_LO = scr_pkg::shadow_lo(ADDR_W, COLOR_W);
    localparam logic [ADDR_W-1:0] CMASK = {{(ADDR_W-COLOR_W){1'b0}}, {COLOR_W{1'b1}}} << OFS_W;
    localparam logic [ADDR_W-1:0] SMASK = {{(ADDR_W-COLOR_W){1'b0}}, {COLOR_W{1'b1}}} << SHADOW_LO;
    localparam logic [ADDR_W-1:0] KEEP  = ~(CMASK | SMASK);

    always_comb begin
        if (fill_valid) begin
            a_r1_new_color: assert (llc_addr[OFS_W +: COLOR_W] == fill_color);
            a_r2_shadow_saves_old: assert (llc_addr[SHADOW_LO +: COLOR_W] == fill_addr[OFS_W +: COLOR_W]);
            a_r3_fwd_bits_kept: assert ((llc_addr & KEEP) == (fill_addr & KEEP));
            if (fill_color == fill_addr[OFS_W +: COLOR_W]) begin
                a_r7_same_color: assert (((llc_addr ^ fill_addr) & ~SMASK) == '0);
            end
        end
        if (evict_valid) begin
            a_r4_shadow_cleared: assert ((mem_addr & SMASK) == '0);
            a_r4_color_restored: assert (mem_addr[OFS_W +: COLOR_W] == evict_addr[SHADOW_LO +: COLOR_W]);
            a_r5_rev_bits_kept: assert ((mem_addr & KEEP) == (evict_addr & KEEP));
        end
        a_r8_fwd_handshake: assert (llc_valid == fill_valid && fill_ready == llc_ready);
        a_r9_rev_handshake: assert (mem_valid == evict_valid && evict_ready == mem_ready);
    end
endmodule

bind shadow_color_remap scr_check #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .COLOR_W(COLOR_W)
) u_scr_check (
    .fill_valid  (fill_valid),
    .fill_ready  (fill_ready),
    .fill_addr   (fill_addr),
    .fill_color  (fill_color),
    .llc_valid   (llc_valid),
    .llc_ready   (llc_ready),
    .llc_addr    (llc_addr),
    .evict_valid (evict_valid),
    .evict_ready (evict_ready),
    .evict_addr  (evict_addr),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr)
);

// File: tb/shadow_color_remap_bench.sv
module shadow_color_remap_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        fill_valid = 1'b0, llc_ready = 1'b0;
    logic        evict_valid = 1'b0, mem_ready = 1'b0;
    logic [47:0] fill_addr = '0, evict_drv = '0;
    logic [3:0]  fill_color = '0;
    logic        loop_en = 1'b0;
    logic        fill_ready, llc_valid, evict_ready, mem_valid;
    logic [47:0] llc_addr, mem_addr, evict_addr;

    // Loop mode feeds the cache-bound result straight into the memory-bound path.
    assign evict_addr = loop_en ? llc_addr : evict_drv;

    shadow_color_remap u_shadow_color_remap (
        .fill_valid (fill_valid), .fill_ready (fill_ready),
        .fill_addr (fill_addr), .fill_color (fill_color),
        .llc_valid (llc_valid), .llc_ready (llc_ready), .llc_addr (llc_addr),
        .evict_valid (evict_valid), .evict_ready (evict_ready), .evict_addr (evict_addr),
        .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_addr (mem_addr)
    );

    typedef struct {
        logic [47:0] llc;
        logic [47:0] mem;
        logic        fv, lr, ev, mr, loop, same;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    function automatic logic [47:0] model_fwd(logic [47:0] a, logic [3:0] c);
        longint unsigned x = {16'd0, a};
        longint unsigned old = (x >> 12) & 64'hF;
        x = x & ~(64'hF << 12) & ~(64'hF << 44);
        x = x | ({60'd0, c} << 12) | (old << 44);
        return x[47:0];
    endfunction

    function automatic logic [47:0] model_rev(logic [47:0] a);
        longint unsigned x = {16'd0, a};
        longint unsigned saved = (x >> 44) & 64'hF;
        x = x & ~(64'hF << 12) & ~(64'hF << 44);
        return x[47:0] | 48'(saved << 12);
    endfunction

    task automatic check(string req, logic [47:0] act, logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic [47:0] fa, logic [3:0] fc, logic fv, logic lr,
                        logic [47:0] ea, logic ev, logic mr, logic lp);
        exp_t e;
        @(posedge clk);
        fill_addr = fa; fill_color = fc; fill_valid = fv; llc_ready = lr;
        evict_drv = ea; evict_valid = ev; mem_ready = mr; loop_en = lp;
        e.llc  = model_fwd(fa, fc);
        e.mem  = lp ? (fa & ~(48'hF << 44)) : model_rev(ea);
        e.fv = fv; e.lr = lr; e.ev = ev; e.mr = mr; e.loop = lp;
        e.same = (fc == fa[15:12]);
        q.push_back(e);
        @(negedge clk);
        e = q.pop_front();
        if (e.fv) begin
            if (e.same) check("R7 same color", llc_addr, e.llc);
            else        check("R1 R2 R3 forward", llc_addr, e.llc);
        end
        if (e.ev) begin
            if (e.loop) check("R6 round trip", mem_addr, e.mem);
            else        check("R4 R5 reverse", mem_addr, e.mem);
        end
        check("R8 fwd handshake", {46'd0, llc_valid, fill_ready}, {46'd0, e.fv, e.lr});
        check("R9 rev handshake", {46'd0, mem_valid, evict_ready}, {46'd0, e.ev, e.mr});
    endtask

    function automatic logic [47:0] rnd48();
        return {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
    endfunction

    initial begin
        // Idle period while the bench holds reset: no valid may appear.
        repeat (4) begin
            @(negedge clk);
            check("R8 idle", {47'd0, llc_valid}, 48'd0);
            check("R9 idle", {47'd0, mem_valid}, 48'd0);
        end
        rst_n = 1'b1;

        // Directed corners.
        step(48'h0, 4'h0, 1, 1, 48'h0, 1, 1, 0);
        step(48'hFFFF_FFFF_FFFF, 4'h0, 1, 0, 48'hFFFF_FFFF_FFFF, 1, 0, 0);
        step(48'h0, 4'hF, 1, 1, 48'hF000_0000_0000, 1, 1, 0);
        step(48'h0000_0000_A123, 4'h5, 1, 1, 48'h3000_0000_5123, 1, 1, 0);
        step(48'h0FFF_FFFF_0FFF, 4'hF, 1, 0, 48'h0FFF_FFFF_FFFF, 1, 1, 0);
        step(48'h1234_5678_9ABC, 4'h9, 1, 1, 48'h0, 0, 1, 0);     // R7: color unchanged
        step(48'hFFFF_FFFF_FFFF, 4'hF, 1, 1, 48'h0, 0, 0, 0);     // R7 with all ones
        step(48'h0000_0001_0000, 4'h1, 1, 1, 48'h0000_0000_0800, 1, 1, 0);
        step(48'h0, 4'h3, 0, 1, 48'h0, 0, 1, 0);                  // R8 R9 invalid

        // Random traffic on both paths with independent handshakes.
        for (int i = 0; i < 400; i++) begin
            logic [47:0] a = rnd48();
            logic [3:0]  c = 4'($urandom());
            if (i % 7 == 0) c = a[15:12];
            step(a, c, 1'($urandom()), 1'($urandom()), rnd48(),
                 1'($urandom()), 1'($urandom()), 0);
        end

        // R6: forward then reverse returns the address, shadow bits cleared.
        for (int i = 0; i < 300; i++) begin
            logic [47:0] a = rnd48();
            if (i % 2 == 0) a[47:44] = 4'h0;
            step(a, 4'($urandom()), 1, 1, 48'h0, 1, 1, 1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule